// File: doc/BRIEF.md
# Scan Completion Interrupt Status

This block keeps the end-of-scan status for a sampling controller that drives two converters, A and B. A sequencer outside the block sends a one-cycle done strobe from each converter whenever a scan finishes. The block decides which of two sticky flags that completion belongs to. The primary flag collects every finished scan, except one case: in non-simultaneous parallel mode, a finished scan on converter B sets the secondary flag instead.

Software reads both flags through a small register port and clears them with a write of one to the flag's bit. It may also leave interrupts off and poll the primary flag as its scan-complete indication. Each flag drives a registered interrupt line that is gated by its own enable input. Both flags always record completions, whatever the state of the enables.

Top module: `scan_eos_status`

## Requirements
- R1: The primary flag (status bit 0) sets one cycle after a converter A done strobe in any scan mode. It also sets after a converter B done strobe when `scan_mode` is 0 (sequential), 1 (simultaneous parallel) or 3 (treated like sequential).
- R2: The secondary flag (status bit 1) sets only after a converter B done strobe while `scan_mode` is 2 (non-simultaneous parallel). That strobe leaves the primary flag unchanged.
- R3: A write to the status address (`STAT_ADDR`, default 0) with bit 0 set clears the primary flag, and with bit 1 set clears the secondary flag. The clear takes effect one cycle after the write.
- R4: Register writes never set a flag. Writing zero bits, writing unimplemented bits, or writing any other address leaves both flags unchanged.
- R5: Every done strobe sets its flag, and this includes repeated iterations with `loop_mode` high. A flag cleared between two iterations sets again after the next strobe.
- R6: Each interrupt output is registered. It equals the new flag value ANDed with that flag's enable, as sampled at the same clock edge. A flag still sets while its enable is low.
- R7: During reset and on the first cycle after it, both flags, both interrupts and the read data are zero.
- R8: When a completion strobe and a clear write for the same flag arrive in the same cycle, the flag ends up set.
- R9: A read of the status address returns the flags on bits 0 and 1, with every other bit zero, one cycle after the read. A read of any other address returns zero. `reg_rdata` is zero in cycles with no read. Reading does not clear a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_done_a | input | 1 | Converter A scan finished (one-cycle strobe) |
| scan_done_b | input | 1 | Converter B scan finished (one-cycle strobe) |
| scan_mode | input | 2 | 0 sequential, 1 simultaneous parallel, 2 non-simultaneous parallel, 3 as sequential |
| loop_mode | input | 1 | Sequencer is running a looping scan |
| irq_en_pri | input | 1 | Interrupt enable for the primary flag |
| irq_en_sec | input | 1 | Interrupt enable for the secondary flag |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data, ones clear flags |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| eos_flag | output | 1 | Primary end-of-scan flag |
| b_eos_flag | output | 1 | Secondary (converter B, non-simultaneous) flag |
| eos_irq | output | 1 | Primary interrupt request |
| b_eos_irq | output | 1 | Secondary interrupt request |

## Verification
Some properties are checked on every cycle by the assertions:
- a flag never rises without a completion in the previous cycle;
- a completion always leaves its flag set, even when a clear arrives at the same time;
- a clear occurs only on a write that carries a one;
- the secondary flag rises only after a B strobe in mode 2;
- each interrupt tracks its flag and its enable.

Other behaviour only the bench scenarios can show: the routing of B strobes in each of the four modes, the exact read word, and that reads and non-matching writes leave the flags untouched. The bench also shows repeated set-clear-set cycles under looping operation.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  typedef enum logic [1:0] {
    MODE_SEQ      = 2'd0,
    MODE_SIM_PAR  = 2'd1,
    MODE_NSIM_PAR = 2'd2,
    MODE_RSVD     = 2'd3
  } scan_mode_e;

  localparam int FLAG_PRI  = 0;
  localparam int FLAG_SEC  = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/scan_evt_route.sv
module scan_evt_route
  import scan_irq_pkg::*;
(
  input  logic                 done_a,
  input  logic                 done_b,
  input  logic [1:0]           mode,
  output logic [NUM_FLAGS-1:0] set_vec
);
  logic nsp;

  always_comb begin
    nsp = (mode == MODE_NSIM_PAR);
    set_vec = '0;
    set_vec[FLAG_PRI] = done_a | (done_b & ~nsp);
    set_vec[FLAG_SEC] = done_b & nsp;
  end
endmodule

// File: rtl/scan_sticky_flag.sv
module scan_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, irq_q;

  always_comb flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(set_i)); // R4
  AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (rst)
    $past(set_i && !rst) |-> flag_q); // R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    $past(clr_i && !set_i && !rst) |-> !flag_q); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && $past(en_i))); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (flag_q && $past(en_i && !rst)) |-> irq_q); // R6
endmodule

// File: rtl/scan_stat_regs.sv
module scan_stat_regs
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int STAT_ADDR = 0,
  parameter int PRI_BIT   = 0,
  parameter int SEC_BIT   = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 reg_rd,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [NUM_FLAGS-1:0] clr_o,
  output logic [DATA_W-1:0]    reg_rdata
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic              hit;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    hit = (reg_addr == STAT_A);
    clr_o = '0;
    clr_o[FLAG_PRI] = reg_wr & hit & reg_wdata[PRI_BIT];
    clr_o[FLAG_SEC] = reg_wr & hit & reg_wdata[SEC_BIT];
    stat_word = '0;
    stat_word[PRI_BIT] = flags_i[FLAG_PRI];
    stat_word[SEC_BIT] = flags_i[FLAG_SEC];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (reg_rd && hit)
      rdata_q <= stat_word;
    else
      rdata_q <= '0;
  end

  assign reg_rdata = rdata_q;

  AST_CLR_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst)
    (|clr_o) |-> (reg_wr && (reg_wdata != '0))); // R3
  AST_READ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (rdata_q != '0) |-> $past(reg_rd && hit)); // R9
endmodule

// File: rtl/scan_eos_status.sv
module scan_eos_status
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int STAT_ADDR = 0,
  parameter int PRI_BIT   = 0,
  parameter int SEC_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_done_a,
  input  logic              scan_done_b,
  input  logic [1:0]        scan_mode,
  input  logic              loop_mode,
  input  logic              irq_en_pri,
  input  logic              irq_en_sec,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              eos_flag,
  output logic              b_eos_flag,
  output logic              eos_irq,
  output logic              b_eos_irq
);
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, en_vec, flag_vec, irq_vec;

  assign en_vec[FLAG_PRI] = irq_en_pri;
  assign en_vec[FLAG_SEC] = irq_en_sec;

  scan_evt_route u_route (
    .done_a  (scan_done_a),
    .done_b  (scan_done_b),
    .mode    (scan_mode),
    .set_vec (set_vec)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    scan_sticky_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .en_i   (en_vec[g]),
      .flag_o (flag_vec[g]),
      .irq_o  (irq_vec[g])
    );
  end

  scan_stat_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_ADDR (STAT_ADDR),
    .PRI_BIT   (PRI_BIT),
    .SEC_BIT   (SEC_BIT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .flags_i   (flag_vec),
    .clr_o     (clr_vec),
    .reg_rdata (reg_rdata)
  );

  assign eos_flag   = flag_vec[FLAG_PRI];
  assign b_eos_flag = flag_vec[FLAG_SEC];
  assign eos_irq    = irq_vec[FLAG_PRI];
  assign b_eos_irq  = irq_vec[FLAG_SEC];

  AST_SEC_ONLY_NSP: assert property (@(posedge clk) disable iff (rst)
    $rose(b_eos_flag) |-> $past(scan_done_b && scan_mode == MODE_NSIM_PAR)); // R2
  AST_LOOP_REARM: assert property (@(posedge clk) disable iff (rst)
    (loop_mode && scan_done_a) |=> eos_flag); // R5
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (flag_vec == '0 && irq_vec == '0 && reg_rdata == '0)); // R7
endmodule

// File: tb/scan_eos_status_test.sv
module scan_eos_status_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_a = 0, done_b = 0, loop_mode = 0, en_p = 0, en_s = 0;
  logic [1:0] mode = 0;
  logic [3:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [15:0] wd = 0;
  logic [15:0] rdata;
  logic pri, sec, ipri, isec;

  int checks = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  scan_eos_status uut (
    .clk(clk), .rst(rst), .scan_done_a(done_a), .scan_done_b(done_b),
    .scan_mode(mode), .loop_mode(loop_mode), .irq_en_pri(en_p), .irq_en_sec(en_s),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wd), .reg_rd(rd), .reg_rdata(rdata),
    .eos_flag(pri), .b_eos_flag(sec), .eos_irq(ipri), .b_eos_irq(isec)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updated on every edge and compared after it
  logic m_pri = 0, m_sec = 0, m_ip = 0, m_is = 0;
  logic [15:0] m_rd = 0;
  always @(posedge clk) begin
    logic np, ns, sp, ss, cp, cs, hit;
    logic [15:0] nr;
    if (rst) begin
      np = 0; ns = 0; nr = 0;
      m_ip = 0; m_is = 0;
    end else begin
      sp = done_a || (done_b && mode != 2);
      ss = done_b && mode == 2;
      hit = (addr == 0);
      cp = wr && hit && wd[0];
      cs = wr && hit && wd[1];
      nr = (rd && hit) ? {14'd0, m_sec, m_pri} : 16'd0;
      np = sp || (m_pri && !cp);
      ns = ss || (m_sec && !cs);
      m_ip = np && en_p;
      m_is = ns && en_s;
    end
    m_pri = np; m_sec = ns; m_rd = nr;
    #1;
    if (!rst) begin
      chk("R1 model eos_flag", {15'd0, pri}, {15'd0, m_pri});
      chk("R2 model b_eos_flag", {15'd0, sec}, {15'd0, m_sec});
      chk("R6 model eos_irq", {15'd0, ipri}, {15'd0, m_ip});
      chk("R6 model b_eos_irq", {15'd0, isec}, {15'd0, m_is});
      chk("R9 model rdata", rdata, m_rd);
    end
  end

  // drive one cycle of stimulus, then return to idle; outputs then show its effect
  task automatic step(input logic a, input logic b, input logic w,
                      input logic [15:0] d, input logic r, input logic [3:0] ad);
    done_a = a; done_b = b; wr = w; wd = d; rd = r; addr = ad;
    @(negedge clk);
    done_a = 0; done_b = 0; wr = 0; wd = 0; rd = 0; addr = 0;
  endtask

  task automatic clear_all();
    step(0, 0, 1, 16'h0003, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 flags in reset", {14'd0, sec, pri}, 16'd0);
    rst = 0;
    @(negedge clk);
    chk("R7 after reset", {12'd0, isec, ipri, sec, pri}, 16'd0);
    chk("R7 rdata after reset", rdata, 16'd0);

    mode = 0;
    step(1, 0, 0, 0, 0, 0);
    chk("R1 A done seq", {15'd0, pri}, 16'd1);
    step(0, 0, 0, 0, 1, 0);
    chk("R9 read word", rdata, 16'h0001);
    chk("R9 read keeps flag", {15'd0, pri}, 16'd1);
    step(0, 0, 1, 16'h0000, 0, 0);
    chk("R4 write zero", {15'd0, pri}, 16'd1);
    step(0, 0, 1, 16'hFFFF, 0, 5);
    chk("R4 other address", {15'd0, pri}, 16'd1);
    step(0, 0, 1, 16'h0001, 0, 0);
    chk("R3 clear primary", {15'd0, pri}, 16'd0);
    step(0, 0, 1, 16'hFFFC, 0, 0);
    chk("R4 no software set", {14'd0, sec, pri}, 16'd0);

    mode = 2;
    step(0, 1, 0, 0, 0, 0);
    chk("R2 B done nsp", {14'd0, sec, pri}, 16'b10);
    step(1, 0, 0, 0, 0, 0);
    chk("R1 A done nsp", {15'd0, pri}, 16'd1);
    step(0, 0, 0, 0, 1, 0);
    chk("R9 both flags", rdata, 16'h0003);
    step(0, 0, 0, 0, 1, 3);
    chk("R9 other addr read", rdata, 16'h0000);
    step(0, 0, 1, 16'h0002, 0, 0);
    chk("R3 clear secondary", {14'd0, sec, pri}, 16'b01);
    clear_all();

    mode = 1;
    step(0, 1, 0, 0, 0, 0);
    chk("R1 B done simultaneous", {14'd0, sec, pri}, 16'b01);
    clear_all();
    mode = 3;
    step(0, 1, 0, 0, 0, 0);
    chk("R1 B done mode3", {14'd0, sec, pri}, 16'b01);
    clear_all();
    mode = 0;
    step(0, 1, 0, 0, 0, 0);
    chk("R1 B done seq", {14'd0, sec, pri}, 16'b01);
    clear_all();
    mode = 2;
    step(1, 1, 0, 0, 0, 0);
    chk("R2 A and B nsp", {14'd0, sec, pri}, 16'b11);
    clear_all();

    mode = 0;
    step(1, 0, 0, 0, 0, 0);
    chk("R6 enable low", {14'd0, ipri, pri}, 16'b01);
    en_p = 1;
    @(negedge clk);
    chk("R6 enable raised", {15'd0, ipri}, 16'd1);
    en_s = 1; mode = 2;
    step(0, 1, 0, 0, 0, 0);
    chk("R6 secondary irq", {15'd0, isec}, 16'd1);
    clear_all();
    chk("R6 irqs drop", {14'd0, isec, ipri}, 16'd0);

    mode = 0;
    step(1, 0, 1, 16'h0001, 0, 0);
    chk("R8 set beats clear pri", {15'd0, pri}, 16'd1);
    mode = 2;
    step(0, 1, 1, 16'h0002, 0, 0);
    chk("R8 set beats clear sec", {15'd0, sec}, 16'd1);
    clear_all();

    mode = 0; loop_mode = 1;
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0, 0, 0);
      chk("R5 loop iteration sets", {15'd0, pri}, 16'd1);
      step(0, 0, 1, 16'h0001, 0, 0);
      chk("R5 loop iteration cleared", {15'd0, pri}, 16'd0);
    end
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R5 back-to-back", {15'd0, pri}, 16'd1);
    loop_mode = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule